// File: doc/BRIEF.md
# Band-Splitting Feedback Loop Controller

This block is the digital inner loop of a neural recording channel. Each sample from the counter-based ADC is a signed 8-bit word that carries the spike band. That word is passed out unchanged. It also feeds a leaky integrator whose gain is set by a programmable right shift. The integrator is a low-pass filter inside the feedback path. Once the analog loop is closed around it, the ADC output sees a high-pass response. A shift setting can be chosen so that the corner falls near 300 Hz, which divides the 1–300 Hz field-potential band from the 300 Hz–10 kHz spike band.

The integrator state is a signed 9-bit word. It is the low-band output, and it is also the value fed back to the front end. Nine bits cover the low-band signal plus the residual electrode offset. A first-order noise-shaping requantizer runs on a fast oversampling enable of about 2 MHz. On each enable it samples the integrator state and reduces it to a 4-bit level. That level drives a 15-wire thermometer code into a current-summing DAC. The bits dropped by the requantizer are kept in an error register and added back on the next enable, so the average DAC level follows the 9-bit word.

Top module: `bandsplit_loop_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears the integrator to 0, the spike output to 0 and the requantizer error to 0. It also sets the DAC level to mid-scale 8, so `dac_therm` reads 15'h00FF.
- R2: When `sample_valid` is high at a clock edge, `lfp_out` takes the value old `lfp_out` + (`adc_sample` >>> `pole_sel`) after that edge. Both operands are two's complement, and the shift is arithmetic.
- R3: The integrator saturates at +255 and at -256 and never wraps.
- R4: When `sample_valid` is low at an edge, `lfp_out` keeps its value.
- R5: When `sample_valid` is high at an edge, `spike_out` takes `adc_sample` after that edge. Otherwise `spike_out` holds its value.
- R6: When `sd_tick` is high at an edge, the block forms S = `lfp_out` + 256 + E, where E is the 5-bit error register. The level becomes min(floor(S/32), 15) and E becomes S mod 32.
- R7: `dac_therm` is a thermometer code of the level: bit i is 1 exactly when i < level.
- R8: When `sd_tick` is low at an edge, `dac_therm` keeps its value.
- R9: If `sd_tick` and `sample_valid` are high at the same edge, the requantizer uses the integrator value from before that edge's update.
- R10: With `lfp_out` held at a value v where v+256 ≤ 480, the levels over any 32 consecutive ticks add up to exactly v+256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Single-cycle strobe: a new ADC sample is present |
| adc_sample | input | 8 | Signed ADC sample |
| pole_sel | input | 3 | Integrator shift amount, which sets the filter pole |
| sd_tick | input | 1 | Clock enable for the requantizer |
| spike_out | output | 8 | Last ADC sample (spike band) |
| lfp_out | output | 9 | Signed integrator state (low band and feedback word) |
| dac_therm | output | 15 | Thermometer drive to the DAC |

## Verification
The filter strobe and the requantizer enable are independent, so both can be active at the same edge. In that case the requantizer must see the integrator value from before the edge. The bench provokes this with random traffic in which the two strobes overlap often, and with a dedicated phase that asserts both together after a large step in the integrator. A behavioural model applies the requantizer step before the filter step, and the thermometer output is compared against it after every edge. Any use of the updated state makes the DAC level differ by one or more steps.

// File: rtl/bsl_pkg.sv
// Shared sizing for the band-splitting loop controller.
// Assumes: STATE_W > ADC_W and STATE_W > DAC_BITS.
package bsl_pkg;
    localparam int ADC_W    = 8;  // ADC sample width
    localparam int STATE_W  = 9;  // integrator / feedback word width
    localparam int DAC_BITS = 4;  // requantized level width
    localparam int K_W      = 3;  // pole select width
endpackage

// File: rtl/bsl_integrator.sv
// Leaky integrator (low-pass IIR) of the inner feedback loop.
// Adds the arithmetically shifted sample to the state on each sample strobe
// and saturates at the signed STATE_W limits.
// Assumes: sample_valid is a single-cycle strobe; pole_sel is held static
// or changes only between samples.
module bsl_integrator #(
    parameter int ADC_W   = bsl_pkg::ADC_W,
    parameter int STATE_W = bsl_pkg::STATE_W,
    parameter int K_W     = bsl_pkg::K_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  logic [ADC_W-1:0]   adc_sample,
    input  logic [K_W-1:0]     pole_sel,
    output logic [STATE_W-1:0] state_q
);
    localparam int EXT_W = STATE_W + 1;
    localparam logic [STATE_W-1:0] ST_MAX = {1'b0, {(STATE_W-1){1'b1}}};
    localparam logic [STATE_W-1:0] ST_MIN = {1'b1, {(STATE_W-1){1'b0}}};

    logic signed [EXT_W-1:0] samp_ext;
    logic signed [EXT_W-1:0] step_v;
    logic signed [EXT_W-1:0] st_ext;
    logic signed [EXT_W-1:0] sum_v;
    logic [STATE_W-1:0]      state_d;

    assign samp_ext = {{(EXT_W-ADC_W){adc_sample[ADC_W-1]}}, adc_sample};
    assign step_v   = samp_ext >>> pole_sel;
    assign st_ext   = {state_q[STATE_W-1], state_q};
    assign sum_v    = st_ext + step_v;

    // Clamp the widened sum back into the signed state range.
    always_comb begin
        if (sum_v[EXT_W-1] != sum_v[EXT_W-2]) begin
            state_d = sum_v[EXT_W-1] ? ST_MIN : ST_MAX;
        end else begin
            state_d = sum_v[STATE_W-1:0];
        end
    end

    // Integrator state register, advanced only on the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (sample_valid) begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/bsl_sd_requant.sv
// First-order noise-shaping requantizer: STATE_W signed -> DAC_BITS level.
// On each tick it adds the held error to the offset-binary input, keeps the
// low bits as the new error and clamps the level to the top DAC code.
// Assumes: tick is a clock enable at the oversampling rate.
module bsl_sd_requant #(
    parameter int STATE_W  = bsl_pkg::STATE_W,
    parameter int DAC_BITS = bsl_pkg::DAC_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [STATE_W-1:0]  value_in,
    output logic [DAC_BITS-1:0] level_q
);
    localparam int DROP_W = STATE_W - DAC_BITS;
    localparam int LEVELS = (1 << DAC_BITS) - 1;
    localparam logic [DAC_BITS-1:0] MID   = DAC_BITS'(1 << (DAC_BITS-1));
    localparam logic [DAC_BITS:0]   TOP_W = (DAC_BITS+1)'(LEVELS);

    logic [STATE_W-1:0]  offs_v;
    logic [STATE_W:0]    acc_v;
    logic [DAC_BITS:0]   lvl_raw;
    logic [DAC_BITS-1:0] lvl_d;
    logic [DROP_W-1:0]   err_q;

    assign offs_v  = {~value_in[STATE_W-1], value_in[STATE_W-2:0]};
    assign acc_v   = {1'b0, offs_v} + {{(DAC_BITS+1){1'b0}}, err_q};
    assign lvl_raw = acc_v[STATE_W:DROP_W];

    // Clamp the quotient to the highest DAC level.
    always_comb begin
        lvl_d = (lvl_raw > TOP_W) ? TOP_W[DAC_BITS-1:0] : lvl_raw[DAC_BITS-1:0];
    end

    // Error and level registers, advanced only on the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= '0;
            level_q <= MID;
        end else if (tick) begin
            err_q   <= acc_v[DROP_W-1:0];
            level_q <= lvl_d;
        end
    end
endmodule

// File: rtl/bsl_therm_enc.sv
// Binary level to thermometer code: bit i is set when i < level.
// Assumes: level never exceeds the number of output wires.
module bsl_therm_enc #(
    parameter int DAC_BITS = bsl_pkg::DAC_BITS
) (
    input  logic [DAC_BITS-1:0]        level,
    output logic [(1<<DAC_BITS)-2:0]   therm
);
    localparam int WIRES = (1 << DAC_BITS) - 1;

    for (genvar i = 0; i < WIRES; i++) begin : g_wire
        assign therm[i] = (level > DAC_BITS'(i));
    end
endmodule

// File: rtl/bandsplit_loop_ctrl.sv
// Inner feedback loop controller of a neural acquisition channel.
// Passes the spike-band sample through, integrates it into the low-band
// feedback word and requantizes that word to a thermometer DAC drive.
// Assumes: sample_valid and sd_tick are single-cycle enables in the clk domain.
module bandsplit_loop_ctrl #(
    parameter int ADC_W    = bsl_pkg::ADC_W,
    parameter int STATE_W  = bsl_pkg::STATE_W,
    parameter int DAC_BITS = bsl_pkg::DAC_BITS,
    parameter int K_W      = bsl_pkg::K_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_valid,
    input  logic [ADC_W-1:0]            adc_sample,
    input  logic [K_W-1:0]              pole_sel,
    input  logic                        sd_tick,
    output logic [ADC_W-1:0]            spike_out,
    output logic [STATE_W-1:0]          lfp_out,
    output logic [(1<<DAC_BITS)-2:0]    dac_therm
);
    logic [DAC_BITS-1:0] level_w;

    // Spike-band register: holds the most recent ADC sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spike_out <= '0;
        end else if (sample_valid) begin
            spike_out <= adc_sample;
        end
    end

    bsl_integrator #(.ADC_W(ADC_W), .STATE_W(STATE_W), .K_W(K_W)) integ_i (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .adc_sample(adc_sample), .pole_sel(pole_sel), .state_q(lfp_out)
    );

    bsl_sd_requant #(.STATE_W(STATE_W), .DAC_BITS(DAC_BITS)) sd_i (
        .clk(clk), .rst_n(rst_n), .tick(sd_tick),
        .value_in(lfp_out), .level_q(level_w)
    );

    bsl_therm_enc #(.DAC_BITS(DAC_BITS)) therm_i (
        .level(level_w), .therm(dac_therm)
    );
endmodule

// File: rtl/bsl_loop_checker.sv
// Protocol checker for bandsplit_loop_ctrl, attached by bind.
// Assumes: same parameters as the bound instance.
module bsl_loop_checker #(
    parameter int ADC_W    = bsl_pkg::ADC_W,
    parameter int STATE_W  = bsl_pkg::STATE_W,
    parameter int DAC_BITS = bsl_pkg::DAC_BITS,
    parameter int K_W      = bsl_pkg::K_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_valid,
    input logic [ADC_W-1:0]         adc_sample,
    input logic [K_W-1:0]           pole_sel,
    input logic                     sd_tick,
    input logic [ADC_W-1:0]         spike_out,
    input logic [STATE_W-1:0]       lfp_out,
    input logic [(1<<DAC_BITS)-2:0] dac_therm
);
    localparam int WIRES = (1 << DAC_BITS) - 1;
    localparam logic [STATE_W-1:0] ST_MAX = {1'b0, {(STATE_W-1){1'b1}}};

    logic [WIRES-1:0] therm_inc;
    assign therm_inc = dac_therm + WIRES'(1);

    AST_RESET_MID: assert property (@(posedge clk)
        !rst_n |=> $countones(dac_therm) == (1 << (DAC_BITS-1))); // R1
    AST_POS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && lfp_out == ST_MAX && !adc_sample[ADC_W-1]) |=> lfp_out == ST_MAX); // R3
    AST_LFP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(lfp_out)); // R4
    AST_SPIKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> spike_out == $past(adc_sample)); // R5
    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_inc & dac_therm) == '0); // R7
    AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_tick |=> $stable(dac_therm)); // R8
endmodule

bind bandsplit_loop_ctrl bsl_loop_checker #(
    .ADC_W(ADC_W), .STATE_W(STATE_W), .DAC_BITS(DAC_BITS), .K_W(K_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .adc_sample(adc_sample), .pole_sel(pole_sel), .sd_tick(sd_tick),
    .spike_out(spike_out), .lfp_out(lfp_out), .dac_therm(dac_therm)
);

// File: tb/bandsplit_loop_ctrl_tb_top.sv
// Self-checking bench with a behavioural per-cycle reference model.
module bandsplit_loop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [7:0]  adc_sample = '0;
    logic [2:0]  pole_sel = '0;
    logic        sd_tick = 1'b0;
    logic [7:0]  spike_out;
    logic [8:0]  lfp_out;
    logic [14:0] dac_therm;

    int checks = 0;
    int errors = 0;
    // reference model state
    int m_st = 0, m_err = 0, m_lvl = 8, m_spk = 0;

    always #2ns clk = ~clk;

    bandsplit_loop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .adc_sample(adc_sample), .pole_sel(pole_sel), .sd_tick(sd_tick),
        .spike_out(spike_out), .lfp_out(lfp_out), .dac_therm(dac_therm)
    );

    function automatic logic [14:0] therm_of(int lvl);
        logic [14:0] t = '0;
        for (int i = 0; i < 15; i++) if (i < lvl) t[i] = 1'b1;
        return t;
    endfunction

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare all outputs against the model; tags name the requirement.
    task automatic compare_all(string lfp_req, string th_req);
        check_int(lfp_req, int'($signed(lfp_out)), m_st);
        check_int("R5 spike", int'($signed(spike_out)), m_spk);
        check_int(th_req, int'(dac_therm), int'(therm_of(m_lvl)));
    endtask

    // One clock: drive at negedge, advance model, compare at next negedge.
    task automatic step(bit v, int samp, int k, bit tk, string lfp_req, string th_req);
        int s, t, u;
        sample_valid = v; adc_sample = 8'(samp); pole_sel = 3'(k); sd_tick = tk;
        if (tk) begin // R9: requantizer sees pre-update state
            u = m_st + 256 + m_err;
            m_err = u % 32;
            m_lvl = (u / 32 > 15) ? 15 : u / 32;
        end
        if (v) begin
            s = int'($signed(8'(samp)));
            t = m_st + (s >>> k);
            if (t > 255) t = 255;
            if (t < -256) t = -256;
            m_st = t;
            m_spk = s;
        end
        @(negedge clk);
        compare_all(lfp_req, th_req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int sum;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_int("R1 lfp", int'($signed(lfp_out)), 0);
        check_int("R1 spike", int'(spike_out), 0);
        check_int("R1 therm", int'(dac_therm), 'h00FF);
        rst_n = 1'b1;
        // R2 and R9: random traffic with frequent overlap of the two strobes
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) == 0, $urandom % 256, $urandom % 8, ($urandom % 2) == 0,
                 "R2 lfp", "R6 R7 therm");
        // R3: positive then negative saturation
        for (int i = 0; i < 6; i++) step(1, 127, 0, 0, "R3 lfp", "R8 therm");
        check_int("R3 max", int'($signed(lfp_out)), 255);
        for (int i = 0; i < 8; i++) step(1, -128, 0, 0, "R3 lfp", "R8 therm");
        check_int("R3 min", int'($signed(lfp_out)), -256);
        // R4: no strobe, value held while sample bus toggles
        for (int i = 0; i < 20; i++) step(0, $urandom % 256, 0, 1, "R4 lfp", "R6 therm");
        check_int("R4 hold", int'($signed(lfp_out)), -256);
        // R9: big step and tick at the same edge
        step(1, 127, 0, 1, "R2 lfp", "R9 therm");
        step(1, 127, 0, 1, "R2 lfp", "R9 therm");
        step(1, -100, 0, 1, "R2 lfp", "R9 therm");
        // R10: hold lfp at a known value, sum 32 levels
        for (int i = 0; i < 8; i++) step(1, -128, 0, 0, "R3 lfp", "R8 therm");
        step(1, 100, 0, 0, "R2 lfp", "R8 therm");
        sum = 0;
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 0, 1, "R4 lfp", "R6 therm");
            sum += $countones(dac_therm);
        end
        check_int("R10 average", sum, 100);
        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        m_st = 0; m_err = 0; m_lvl = 8; m_spk = 0;
        compare_all("R1 lfp", "R1 therm");
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++)
            step(($urandom % 2) == 0, $urandom % 256, $urandom % 8, ($urandom % 4) == 0,
                 "R2 lfp", "R7 therm");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule